// File: doc/BRIEF.md
# EEPROM page write buffer

This block gathers the data bytes of one serial-memory write transaction and later commits them to a byte-wide memory array. A transaction begins with a start strobe that loads a 13-bit word address into the internal pointer. Each data byte that follows lands in a 32-entry page buffer at the slot named by the pointer's five low bits. After each byte, only those low bits advance, so a long burst wraps inside the page and later bytes overwrite earlier ones.

Nothing reaches the array until the commit strobe, which stands for the bus stop condition and carries the write-protect level sampled at that moment. If protection is off, a sequencer walks the loaded slots in ascending order and issues one write per clock on a simple synchronous write port. It then pulses done. If protection is on, or nothing was loaded, done follows at once and the array is untouched. An abort discards the loaded bytes and cancels a commit in progress. The pointer is kept between transactions and always names the location after the last byte received, wrapped within its page.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are 0 and ptr_o is 0.
- R2: A start strobe accepted while idle loads start_addr_i into ptr_o and forgets any bytes loaded earlier.
- R3: Each accepted data byte is stored at slot ptr_o[4:0]. After it, ptr_o[4:0] increments modulo 32 and ptr_o[12:5] stays unchanged.
- R4: When more than 32 bytes arrive before commit, the newest byte for a slot replaces the older one, and only the newest is written.
- R5: mem_we_o stays 0 until commit. After an unprotected commit, each loaded slot is written exactly once, in ascending slot order. The writes go one per cycle, starting the cycle after the commit strobe, at address {ptr_o[12:5], slot} with that slot's newest byte.
- R6: done_o is a one-cycle pulse. It comes in the cycle after the final write, or in the cycle after the commit strobe when no write takes place.
- R7: With wp_i high at the commit strobe, no write is issued. The level of wp_i at any other time has no effect.
- R8: After a commit, ptr_o names the location after the last byte received, wrapping within its 32-byte page (0x1FFF is followed by 0x1FE0).
- R9: abort_i takes priority over all other inputs. It discards loaded bytes, leaves ptr_o unchanged, and during a commit it stops further writes with no done pulse.
- R10: While busy_o is high, start, data and commit strobes are ignored.
- R11: A start and a data byte in the same cycle put the byte at start_addr_i. A data byte together with the commit strobe is included in that commit.
- R12: A single-byte write follows the same path as a page write of one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load start address, begin a transaction |
| start_addr_i | input | 13 | Word address of the first byte |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Commit strobe |
| wp_i | input | 1 | Write-protect level, taken with stop_i |
| abort_i | input | 1 | Discard the transaction |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 13 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| done_o | output | 1 | Commit finished pulse |
| busy_o | output | 1 | Commit in progress |
| ptr_o | output | 13 | Internal address pointer |

## Verification
The bench drives two pairs of events into the same cycle. The first pair is a start strobe with a data byte. Here the bench expects the byte at the new start address and the pointer one past it. The second pair is a data byte with the commit strobe. Here the bench expects the byte among the committed writes, with the pointer advanced past it. Both cases are judged against a bench-side page model, write by write, at the array port. The bench also runs abort against an active commit: it expects exactly the writes issued before the abort and no done pulse.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_ADDR_W = 13;
  localparam int unsigned PWB_DATA_W = 8;
  localparam int unsigned PWB_SLOT_W = 5;
endpackage

// File: rtl/pwb_fill.sv
module pwb_fill
  import pwb_pkg::*;
#(
  parameter int unsigned AW = PWB_ADDR_W,
  parameter int unsigned DW = PWB_DATA_W,
  parameter int unsigned SB = PWB_SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          commit_i,
  input  logic [SB-1:0] rd_slot_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] ptr_o,
  output logic [(1<<SB)-1:0] mask_next_o
);
  localparam int unsigned PG = 1 << SB;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    logic [SB-1:0] lo;
    lo = p[SB-1:0] + 1'b1;
    return {p[AW-1:SB], lo};
  endfunction

  logic [AW-1:0] ptr_q, base_ptr;
  logic [PG-1:0] mask_q, base_mask, slot_bit;
  logic [DW-1:0] page_q [PG];
  logic          accept, take_start, byte_take;
  logic [SB-1:0] wr_slot;

  assign accept     = !hold_i && !abort_i;
  assign take_start = accept && start_i;
  assign byte_take  = accept && byte_vld_i;
  assign base_ptr   = take_start ? start_addr_i : ptr_q;
  assign base_mask  = take_start ? '0 : mask_q;
  assign wr_slot    = base_ptr[SB-1:0];

  always_comb begin
    slot_bit = '0;
    if (byte_take) slot_bit[wr_slot] = 1'b1;
  end

  assign mask_next_o = base_mask | slot_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      ptr_q  <= byte_take ? ptr_step(base_ptr) : base_ptr;
      mask_q <= (abort_i || commit_i) ? '0 : mask_next_o;
    end
  end

  always_ff @(posedge clk) begin
    if (byte_take) page_q[wr_slot] <= byte_i;
  end

  assign rd_data_o = page_q[rd_slot_i];
  assign ptr_o     = ptr_q;

  // R3
  page_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_i) |=> ptr_q[AW-1:SB] == $past(ptr_q[AW-1:SB]));

  // R9
  abort_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (ptr_q == $past(ptr_q)) && (mask_q == '0));
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
  import pwb_pkg::*;
#(
  parameter int unsigned SB = PWB_SLOT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic                wp_i,
  input  logic                abort_i,
  input  logic [(1<<SB)-1:0]  load_mask_i,
  output logic                busy_o,
  output logic                we_o,
  output logic [SB-1:0]       slot_o,
  output logic                done_o
);
  localparam int unsigned PG = 1 << SB;

  function automatic logic [SB-1:0] lowest_slot(input logic [PG-1:0] m);
    logic [SB-1:0] r;
    r = '0;
    for (int i = PG - 1; i >= 0; i--) if (m[i]) r = SB'(i);
    return r;
  endfunction

  logic [PG-1:0] pend_q, slot_bit;
  logic          busy_q, done_q, last_write, skip_commit;

  assign slot_o = lowest_slot(pend_q);

  always_comb begin
    slot_bit = '0;
    slot_bit[slot_o] = 1'b1;
  end

  assign last_write  = (pend_q & ~slot_bit) == '0;
  assign skip_commit = wp_i || (load_mask_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        pend_q <= '0;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        pend_q <= pend_q & ~slot_bit;
        if (last_write) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (fire_i) begin
        if (skip_commit) done_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          pend_q <= load_mask_i;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign done_o = done_q;

  // R5
  one_slot_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !abort_i) |=> $countones(pend_q) == $countones($past(pend_q)) - 1);

  // R6
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  protected_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !busy_q && wp_i && !abort_i) |=> !busy_q && done_q);

  // R9
  abort_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_q && !done_q);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int unsigned AW = PWB_ADDR_W,
  parameter int unsigned DW = PWB_DATA_W,
  parameter int unsigned SB = PWB_SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic          abort_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o,
  output logic          busy_o,
  output logic [AW-1:0] ptr_o
);
  localparam int unsigned PG = 1 << SB;

  logic          busy, commit_fire, seq_we;
  logic [SB-1:0] seq_slot;
  logic [PG-1:0] fill_mask;
  logic [DW-1:0] slot_data;
  logic [AW-1:0] ptr;

  assign commit_fire = stop_i && !busy && !abort_i;

  pwb_fill #(.AW(AW), .DW(DW), .SB(SB)) u_fill (
    .clk(clk), .rst_n(rst_n), .hold_i(busy), .abort_i(abort_i),
    .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_fire),
    .rd_slot_i(seq_slot), .rd_data_o(slot_data), .ptr_o(ptr),
    .mask_next_o(fill_mask)
  );

  pwb_commit #(.SB(SB)) u_commit (
    .clk(clk), .rst_n(rst_n), .fire_i(commit_fire), .wp_i(wp_i),
    .abort_i(abort_i), .load_mask_i(fill_mask), .busy_o(busy),
    .we_o(seq_we), .slot_o(seq_slot), .done_o(done_o)
  );

  assign mem_we_o    = seq_we;
  assign mem_addr_o  = {ptr[AW-1:SB], seq_slot};
  assign mem_wdata_o = slot_data;
  assign busy_o      = busy;
  assign ptr_o       = ptr;

  // R5
  write_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_addr_o[AW-1:SB] == ptr_o[AW-1:SB]);

  // R10
  busy_freezes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !abort_i) |=> ptr_o == $past(ptr_o));
endmodule

// File: tb/page_write_buffer_test.sv
`timescale 1ns/1ps
module page_write_buffer_test;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int SB = 5;
  localparam int PG = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, byte_vld_i = 0, stop_i = 0, wp_i = 0, abort_i = 0;
  logic [AW-1:0] start_addr_i = '0;
  logic [DW-1:0] byte_i = '0;
  logic mem_we_o, done_o, busy_o;
  logic [AW-1:0] mem_addr_o, ptr_o;
  logic [DW-1:0] mem_wdata_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_buf [PG];
  logic [PG-1:0] m_mask = '0;
  logic [AW-1:0] m_ptr = '0;

  always #5 clk = ~clk;

  page_write_buffer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
    .abort_i(abort_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .busy_o(busy_o), .ptr_o(ptr_o)
  );

  function automatic logic [AW-1:0] next_loc(input logic [AW-1:0] p);
    logic [AW-1:0] lowm;
    lowm = AW'(PG - 1);
    return (p & ~lowm) | ((p + 1'b1) & lowm);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_byte(input logic [DW-1:0] b);
    m_buf[m_ptr[SB-1:0]] = b;
    m_mask[m_ptr[SB-1:0]] = 1'b1;
    m_ptr = next_loc(m_ptr);
  endtask

  task automatic idle();
    start_i = 0; byte_vld_i = 0; stop_i = 0; abort_i = 0;
    @(negedge clk);
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    start_i = 1; start_addr_i = a;
    @(negedge clk);
    start_i = 0;
    m_ptr = a; m_mask = '0;
    chk(ptr_o == a, "R2", "ptr after start", ptr_o, a);
  endtask

  task automatic do_byte(input logic [DW-1:0] b, input bit st, input logic [AW-1:0] a);
    if (st) begin m_ptr = a; m_mask = '0; end
    model_byte(b);
    start_i = st; start_addr_i = a; byte_vld_i = 1; byte_i = b;
    @(negedge clk);
    start_i = 0; byte_vld_i = 0;
    chk(ptr_o == m_ptr, st ? "R11" : "R3", "ptr after byte", ptr_o, m_ptr);
    chk(!mem_we_o, "R5", "write before commit", mem_we_o, 0);
  endtask

  task automatic check_commit(input bit wp);
    if (wp || m_mask == '0) begin
      chk(!mem_we_o, "R7", "write while protected or empty", mem_we_o, 0);
    end else begin
      for (int s = 0; s < PG; s++) begin
        if (m_mask[s]) begin
          chk(mem_we_o, "R5", "write enable", mem_we_o, 1);
          chk(mem_addr_o == {m_ptr[AW-1:SB], SB'(s)}, "R5", "write address",
              mem_addr_o, {m_ptr[AW-1:SB], SB'(s)});
          chk(mem_wdata_o == m_buf[s], "R4", "write data", mem_wdata_o, m_buf[s]);
          chk(!done_o, "R6", "done during writes", done_o, 0);
          wp_i = 1'($urandom);
          @(negedge clk);
        end
      end
    end
    chk(done_o, "R6", "done pulse", done_o, 1);
    chk(!mem_we_o, "R5", "no write with done", mem_we_o, 0);
    idle();
    chk(!done_o, "R6", "done width", done_o, 0);
    chk(ptr_o == m_ptr, "R8", "ptr after commit", ptr_o, m_ptr);
    m_mask = '0;
  endtask

  task automatic do_stop(input bit wp, input bit wb, input logic [DW-1:0] b);
    if (wb) model_byte(b);
    stop_i = 1; wp_i = wp; byte_vld_i = wb; byte_i = b;
    @(negedge clk);
    stop_i = 0; byte_vld_i = 0;
    wp_i = 1'($urandom);
    check_commit(wp);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E));
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_we_o && ptr_o == '0, "R1", "reset state",
        {busy_o, done_o, mem_we_o}, 0);
    rst_n = 1;
    idle();

    // R12 single byte
    do_start(13'h0ABC);
    do_byte(8'h5A, 0, '0);
    do_stop(0, 0, '0);
    chk(ptr_o == 13'h0ABD, "R12", "ptr after single byte", ptr_o, 13'h0ABD);

    // R8 wrap of following location
    do_start(13'h1FFF);
    do_byte(8'hC3, 0, '0);
    chk(ptr_o == 13'h1FE0, "R8", "wrap at page end", ptr_o, 13'h1FE0);
    do_stop(0, 0, '0);

    // R4 overrun of 34 bytes
    do_start(13'h1FFE);
    for (int i = 0; i < 34; i++) do_byte(DW'(i + 8'h40), 0, '0);
    chk(ptr_o == 13'h1FE0, "R3", "ptr after 34 bytes", ptr_o, 13'h1FE0);
    do_stop(0, 0, '0);

    // R7 protected commit
    do_start(13'h0400);
    for (int i = 0; i < 5; i++) do_byte(8'hE0 + DW'(i), 0, '0);
    do_stop(1, 0, '0);

    // R11 start+byte and byte+stop
    do_start(13'h0010);
    do_byte(8'h11, 1, 13'h0735);
    do_byte(8'h22, 0, '0);
    do_stop(0, 1, 8'h33);

    // R9 abort during fill
    do_start(13'h0300);
    for (int i = 0; i < 3; i++) do_byte(8'h70 + DW'(i), 0, '0);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    m_mask = '0;
    chk(ptr_o == m_ptr, "R9", "ptr kept on abort", ptr_o, m_ptr);
    do_stop(0, 0, '0);

    // R9 abort during commit
    do_start(13'h0100);
    for (int i = 0; i < 4; i++) do_byte(8'h90 + DW'(i), 0, '0);
    stop_i = 1; wp_i = 0;
    @(negedge clk);
    stop_i = 0;
    chk(mem_we_o && mem_addr_o == 13'h0100, "R5", "first write", mem_addr_o, 13'h0100);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    chk(!mem_we_o && !busy_o, "R9", "writes stopped", mem_we_o, 0);
    chk(!done_o, "R9", "no done after abort", done_o, 0);
    idle();
    chk(!done_o && !mem_we_o, "R9", "quiet after abort", done_o, 0);
    m_mask = '0;

    // R10 inputs ignored while busy
    do_start(13'h0200);
    for (int i = 0; i < 3; i++) do_byte(8'hA0 + DW'(i), 0, '0);
    stop_i = 1; wp_i = 0;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      chk(mem_we_o && mem_addr_o == 13'h0200 + AW'(s) && mem_wdata_o == 8'hA0 + DW'(s),
          "R10", "write while inputs toggle", mem_addr_o, 13'h0200 + s);
      start_i = 1; start_addr_i = 13'h0555; byte_vld_i = 1; byte_i = 8'hFF; stop_i = 1;
      @(negedge clk);
    end
    start_i = 0; byte_vld_i = 0; stop_i = 0;
    chk(done_o, "R6", "done after busy window", done_o, 1);
    idle();
    chk(ptr_o == 13'h0203, "R10", "ptr not moved while busy", ptr_o, 13'h0203);
    m_mask = '0;
    do_stop(0, 0, '0);

    // random transactions
    for (int t = 0; t < 24; t++) begin
      int n;
      do_start(AW'($urandom));
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) begin
        do_byte(DW'($urandom), 0, '0);
        if ($urandom % 5 == 0) idle();
      end
      do_stop(($urandom % 4) == 0, ($urandom % 3) == 0, DW'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule